// File: doc/BRIEF.md
# Associative Virtual-to-Physical Block Translator

This block converts a processor's virtual address into a physical address within a shared on-chip memory. That memory is split into equal-sized global blocks, and the block size is a power of two. The upper bits of the incoming address form a virtual block number. The lower bits are the offset inside the block.

The block holds a table with one row for each physical block. Each row stores a virtual block tag and a valid flag. On every lookup, all rows are compared against the virtual block number at the same time. The position of the matching row, encoded in binary, is the physical block number. No physical field is stored anywhere in the table.

The physical address is the physical block number placed above the unchanged offset. If no row matches, the lookup reports a miss and drives a zero address. Software loads and retires mappings through a single row-write port. A write takes effect on the clock edge, and the lookup path is purely combinational.

Top module: `vbt_translator`

## Requirements
- R1: A synchronous active-high reset clears every row's valid flag. After reset, every lookup misses until a row is written.
- R2: The virtual block number is `lk_vaddr[ADDR_W-1:OFF_W]` and the offset is `lk_vaddr[OFF_W-1:0]`. The defaults are ADDR_W=32 and OFF_W=13, which gives a 19-bit tag and 8 KB blocks.
- R3: A lookup hits when some valid row's tag equals the virtual block number. On a hit, `lk_hit`=1, `lk_miss`=0 and `lk_paddr` = (row index << OFF_W) | offset, with all bits above the row index equal to zero.
- R4: On a hit, the offset bits of `lk_paddr` equal the offset bits of `lk_vaddr`.
- R5: A write with `wr_en`=1 stores `wr_tag` and `wr_valid` into row `wr_row` at the clock edge. A lookup in the same cycle as the write still sees the old contents, and the new contents are seen from the next cycle on.
- R6: When no valid row matches, `lk_miss`=1, `lk_hit`=0 and `lk_paddr`=0.
- R7: A row whose valid flag is 0 never matches, whatever tag it holds. Writing `wr_valid`=0 retires a mapping.
- R8: When several valid rows hold the same tag, the row with the lowest index gives the physical block number.
- R9: The lookup is combinational. `lk_paddr`, `lk_hit` and `lk_miss` follow a change of `lk_vaddr` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | RIDX_W (8) | Row index to write |
| wr_tag | input | VBN_W (19) | Virtual block tag to store |
| wr_valid | input | 1 | Valid flag to store |
| lk_vaddr | input | ADDR_W (32) | Virtual address to translate |
| lk_paddr | output | ADDR_W (32) | Translated physical address, zero on a miss |
| lk_hit | output | 1 | Lookup found a mapping |
| lk_miss | output | 1 | Lookup found no mapping |

## Verification
Several properties are checked on every cycle by the assertions:
- A miss always gives a zero address.
- A hit keeps the offset and points at a valid row whose stored tag equals the incoming block number.
- The encoder picks the lowest set match bit.
- A write is found in the addressed row one cycle later.
- Reset leaves every row invalid.

Some behaviours can only be shown by the bench's scenarios against its behavioural table model. These are the one-cycle delay before a write becomes visible to a lookup, duplicate tags resolving to the lowest row after higher rows were loaded first, retirement through a cleared valid flag, and the address changing the result mid-cycle without a clock edge.

// File: rtl/vbt_pkg.sv
package vbt_pkg;
  localparam int unsigned VBT_ADDR_W = 32;
  localparam int unsigned VBT_OFF_W  = 13;
  localparam int unsigned VBT_ROWS   = 256;
endpackage

// File: rtl/vbt_tag_store.sv
module vbt_tag_store #(
  parameter int unsigned ROWS   = vbt_pkg::VBT_ROWS,
  parameter int unsigned VBN_W  = 19,
  localparam int unsigned RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [RIDX_W-1:0]             wr_row,
  input  logic [VBN_W-1:0]              wr_tag,
  input  logic                          wr_valid,
  output logic [ROWS-1:0][VBN_W-1:0]    tags_q,
  output logic [ROWS-1:0]               valid_q
);

  logic row_ok;
  assign row_ok = (int'(wr_row) < int'(ROWS));

  // Tags carry no reset; only the valid flags are cleared.
  always_ff @(posedge clk) begin
    if (wr_en && row_ok) tags_q[wr_row] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en && row_ok) valid_q[wr_row] <= wr_valid;
  end

  // R1: the cycle after reset, no row is valid
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_q == '0));

  // R5: a write is present in its row one cycle later
  p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && row_ok) |=>
      (valid_q[$past(wr_row)] == $past(wr_valid)) && (tags_q[$past(wr_row)] == $past(wr_tag)));

endmodule

// File: rtl/vbt_match.sv
module vbt_match #(
  parameter int unsigned ROWS  = vbt_pkg::VBT_ROWS,
  parameter int unsigned VBN_W = 19
) (
  input  logic [ROWS-1:0][VBN_W-1:0] tags,
  input  logic [ROWS-1:0]            valid,
  input  logic [VBN_W-1:0]           vbn,
  output logic [ROWS-1:0]            match
);

  for (genvar g = 0; g < ROWS; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == vbn);
  end

endmodule

// File: rtl/vbt_prio_enc.sv
module vbt_prio_enc #(
  parameter int unsigned ROWS   = vbt_pkg::VBT_ROWS,
  localparam int unsigned RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROWS-1:0]   vec,
  output logic [RIDX_W-1:0] idx,
  output logic              any
);

  // Walk from the top down so the lowest set bit is the last one written.
  always_comb begin
    idx = '0;
    for (int i = int'(ROWS) - 1; i >= 0; i--) begin
      if (vec[i]) idx = RIDX_W'(i);
    end
  end

  assign any = |vec;

  // R8: chosen bit is set and no lower bit is set
  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (rst)
    any |-> (vec[idx] && ((vec & ~({ROWS{1'b1}} << idx)) == '0)));

endmodule

// File: rtl/vbt_translator.sv
module vbt_translator #(
  parameter int unsigned ADDR_W = vbt_pkg::VBT_ADDR_W,
  parameter int unsigned OFF_W  = vbt_pkg::VBT_OFF_W,
  parameter int unsigned ROWS   = vbt_pkg::VBT_ROWS,
  localparam int unsigned VBN_W  = ADDR_W - OFF_W,
  localparam int unsigned RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_row,
  input  logic [VBN_W-1:0]  wr_tag,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] lk_vaddr,
  output logic [ADDR_W-1:0] lk_paddr,
  output logic              lk_hit,
  output logic              lk_miss
);

  logic [ROWS-1:0][VBN_W-1:0] tags;
  logic [ROWS-1:0]            valid;
  logic [ROWS-1:0]            match;
  logic [RIDX_W-1:0]          row_idx;
  logic                       found;
  logic [VBN_W-1:0]           vbn;
  logic [OFF_W-1:0]           offset;

  assign vbn    = lk_vaddr[ADDR_W-1:OFF_W];
  assign offset = lk_vaddr[OFF_W-1:0];

  vbt_tag_store #(.ROWS(ROWS), .VBN_W(VBN_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row),
    .wr_tag(wr_tag), .wr_valid(wr_valid), .tags_q(tags), .valid_q(valid)
  );

  vbt_match #(.ROWS(ROWS), .VBN_W(VBN_W)) u_match (
    .tags(tags), .valid(valid), .vbn(vbn), .match(match)
  );

  vbt_prio_enc #(.ROWS(ROWS)) u_enc (
    .clk(clk), .rst(rst), .vec(match), .idx(row_idx), .any(found)
  );

  always_comb begin
    if (found) lk_paddr = (ADDR_W'(row_idx) << OFF_W) | ADDR_W'(offset);
    else       lk_paddr = '0;
  end

  assign lk_hit  = found;
  assign lk_miss = !found;

  // R6: a miss yields a zero address
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (lk_paddr == '0));

  // R4: a hit preserves the offset
  p_offset_pass_r4: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  // R3, R7: a hit points at a valid row holding the incoming tag
  p_hit_tag_r3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (valid[lk_paddr[OFF_W +: RIDX_W]] && (tags[lk_paddr[OFF_W +: RIDX_W]] == vbn)));

endmodule

// File: tb/tb_vbt_translator.sv
`timescale 1ns/1ps
module tb_vbt_translator;
  localparam int AW = 32;
  localparam int OW = 13;
  localparam int NR = 256;
  localparam int TW = AW - OW;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [IW-1:0] wr_row;
  logic [TW-1:0] wr_tag;
  logic          wr_valid;
  logic [AW-1:0] lk_vaddr;
  logic [AW-1:0] lk_paddr;
  logic          lk_hit, lk_miss;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [TW-1:0] m_tag [NR];
  bit            m_val [NR];

  always #5 clk = ~clk;

  vbt_translator dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_tag(wr_tag),
    .wr_valid(wr_valid), .lk_vaddr(lk_vaddr), .lk_paddr(lk_paddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss)
  );

  task automatic check(input string req);
    bit            eh = 0;
    logic [AW-1:0] ep = '0;
    for (int i = 0; i < NR; i++) begin
      if (!eh && m_val[i] && m_tag[i] == lk_vaddr[AW-1:OW]) begin
        eh = 1;
        ep = (AW'(i) << OW) | AW'(lk_vaddr[OW-1:0]);
      end
    end
    n_tests++;
    if (lk_hit !== eh || lk_miss !== !eh || lk_paddr !== ep) begin
      n_fail++;
      $display("FAIL %s: hit=%0b miss=%0b paddr=%h expected hit=%0b miss=%0b paddr=%h",
               req, lk_hit, lk_miss, lk_paddr, eh, !eh, ep);
    end
  endtask

  task automatic step(input logic we, input int row, input logic [TW-1:0] tg,
                      input logic v, input logic [AW-1:0] va, input string req);
    @(negedge clk);
    wr_en = we; wr_row = IW'(row); wr_tag = tg; wr_valid = v; lk_vaddr = va;
    #1 check(req);
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NR; i++) m_val[i] = 0;
    end else if (we) begin
      m_tag[row] = tg; m_val[row] = v;
    end
  endtask

  function automatic logic [AW-1:0] mk(input logic [TW-1:0] t, input int off);
    return {t, OW'(off)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_val[i] = 0; m_tag[i] = '0; end
    rst = 1; wr_en = 0; wr_row = '0; wr_tag = '0; wr_valid = 0; lk_vaddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: empty table after reset
    step(0, 0, '0, 0, 32'h0000_0000, "R1");
    step(0, 0, '0, 0, 32'hFFFF_FFFF, "R1");
    step(0, 0, '0, 0, 32'h1234_5678, "R1");

    // R5: lookup during the write cycle sees the old table
    step(1, 5, 19'h00ABC, 1, mk(19'h00ABC, 16), "R5 same-cycle");
    step(0, 0, '0, 0, mk(19'h00ABC, 16), "R5 next-cycle R3");
    // R4: offset extremes
    step(0, 0, '0, 0, mk(19'h00ABC, 0), "R4");
    step(0, 0, '0, 0, mk(19'h00ABC, 8191), "R4");
    // R2: top tag, top row
    step(1, 255, 19'h7FFFF, 1, 32'hFFFF_E001, "R2");
    step(0, 0, '0, 0, 32'hFFFF_FFFF, "R2 R3");
    step(1, 0, 19'h00000, 1, 32'h0000_1FFF, "R2");
    step(0, 0, '0, 0, 32'h0000_1FFF, "R2 R3");
    // R8: duplicate loaded at lower row wins
    step(1, 3, 19'h00ABC, 1, '0, "R8 setup");
    step(0, 0, '0, 0, mk(19'h00ABC, 77), "R8");
    step(1, 200, 19'h00ABC, 1, '0, "R8 setup");
    step(0, 0, '0, 0, mk(19'h00ABC, 78), "R8");
    // R7: retire row 3, row 5 resumes; invalid row with matching tag ignored
    step(1, 3, 19'h00ABC, 0, mk(19'h00ABC, 5), "R7 same-cycle");
    step(0, 0, '0, 0, mk(19'h00ABC, 5), "R7");
    step(1, 9, 19'h01111, 0, '0, "R7 setup");
    step(0, 0, '0, 0, mk(19'h01111, 1), "R7 R6");
    // R6: unmapped tag
    step(0, 0, '0, 0, mk(19'h55555, 4000), "R6");

    // R9: address changes mid-cycle without a clock edge
    @(negedge clk);
    wr_en = 0;
    lk_vaddr = mk(19'h00ABC, 3);  #1 check("R9");
    lk_vaddr = mk(19'h55555, 3);  #1 check("R9");
    lk_vaddr = 32'hFFFF_FFF0;     #1 check("R9");

    // Mixed traffic against the model, small tag pool for frequent hits
    for (int k = 0; k < 600; k++) begin
      logic [TW-1:0] t;
      t = TW'($urandom_range(0, 15));
      step(($urandom_range(0, 2) == 0), int'($urandom_range(0, NR-1)),
           TW'($urandom_range(0, 15)), ($urandom_range(0, 3) != 0),
           mk(t, int'($urandom_range(0, 8191))), "R3 R7 R8 mixed");
    end

    // R1: reset in mid-run empties the table
    @(negedge clk); rst = 1; wr_en = 0;
    @(posedge clk);
    for (int i = 0; i < NR; i++) m_val[i] = 0;
    @(negedge clk); rst = 0;
    step(0, 0, '0, 0, mk(19'h00ABC, 16), "R1 re-reset");
    step(0, 0, '0, 0, 32'hFFFF_FFFF, "R1 re-reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule